// File: doc/BRIEF.md
# OLED Panel Power-Up Command Sequencer

This block brings a monochrome OLED panel controller out of reset and keeps it under control afterwards. It drives the panel's reset pin through a low phase and a high phase. It then sends a fixed list of configuration commands over a write-only SPI link. Each byte goes out in its own chip-select frame, with the data/command select line held at the command level. A few parameter bytes in that list depend on the panel height, which is given on a two-bit input.

When the list is finished, the block drops `busy`. It then accepts three kinds of runtime request: blank the panel, unblank it, or load a new contrast value. Each request produces a short command burst on the same link. Requests that arrive while a burst is in progress are dropped.

Top module: `oled_init_seq`

## Requirements
- R1: After reset is released, `panel_rst_n` stays low for exactly RST_CYC clock cycles. It then stays high for at least RST_CYC cycles before the first SPI frame. It never goes low again until the next reset.
- R2: Each byte is sent in its own frame, with `spi_cs_n` low and `spi_dc` low for the whole frame. The byte is 8 bits, MSB first, in SPI mode 0: SCK idles low and data is stable while SCK is high.
- R3: The power-up bytes are sent in this order: AE, D5 80, A8 M, D3 00, 40, 8D 14, 20 01, A1, C8, DA P, D9 F1, DB 40, A4, A6, AF.
  - `height_sel` encodes the panel height: 2 means 64 rows, 1 means 48 rows, 0 and 3 mean 32 rows.
  - M is 3F for 64 rows, 2F for 48 rows and 1F for 32 rows.
  - P is 12 for 48 or 64 rows and 02 for 32 rows.
- R4: Right after the AF of R3, the bytes 81 and a default contrast value are sent. The default is CF for 64 rows and 8F otherwise.
- R5: `busy` is high from reset until the last power-up byte has been sent, and is high during every runtime burst. While `busy` is low, `spi_cs_n` stays high.
- R6: A blank request accepted while idle sends the single byte AE. An unblank request accepted while idle sends the single byte AF.
- R7: A contrast request accepted while idle sends 81 followed by `contrast_val`, captured in the cycle the request is accepted.
- R8: Requests present while `busy` is high have no effect: no byte is ever sent for them.
- R9: When several requests are present in the same idle cycle, only one is served. Blank wins over unblank, and unblank wins over contrast.
- R10: SCK has a period of 2*CLK_DIV clock cycles inside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| height_sel | input | 2 | Panel height: 2 = 64 rows, 1 = 48 rows, other values = 32 rows; hold stable during power-up |
| blank_req | input | 1 | Request to switch the panel display off |
| unblank_req | input | 1 | Request to switch the panel display on |
| contrast_req | input | 1 | Request to load `contrast_val` as the new contrast |
| contrast_val | input | 8 | Contrast value for a contrast request |
| busy | output | 1 | High while powering up or sending a runtime burst |
| panel_rst_n | output | 1 | Active-low reset pin of the panel |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI data, MSB first |
| spi_cs_n | output | 1 | SPI chip select, low for one byte |
| spi_dc | output | 1 | Data/command select, low during command frames |

## Verification
A wrong step index or a wrong job code in the sequencer shows up at the next frame boundary. The byte that appears on MOSI is then wrong or out of place, and the scoreboard flags it within one byte time (about 16*CLK_DIV cycles). A stuck shifter state shows in one of three ways: SCK stays high outside a frame, a frame ends before all 8 bits, or the SCK period is wrong. All three can be seen within one bit period. A sequencer that never reaches idle keeps `busy` high, so the bench's wait for idle hangs and its cycle limit expires. A sequencer that accepts requests while busy produces extra frames, which the scoreboard reports as unexpected bytes.

// File: rtl/oled_pkg.sv
package oled_pkg;

    typedef enum logic [2:0] {
        S_RST_LO,
        S_RST_HI,
        S_SEND,
        S_WAIT,
        S_IDLE
    } seq_state_e;

    typedef enum logic [1:0] {
        J_INIT,
        J_BLANK,
        J_UNBLANK,
        J_CONTRAST
    } job_e;

    localparam int INIT_LEN = 25;
    localparam int IDX_W    = $clog2(INIT_LEN);

    localparam logic [1:0] H_ROWS48 = 2'd1;
    localparam logic [1:0] H_ROWS64 = 2'd2;

    localparam logic [7:0] C_DISP_OFF = 8'hAE;
    localparam logic [7:0] C_DISP_ON  = 8'hAF;
    localparam logic [7:0] C_CONTRAST = 8'h81;

endpackage

// File: rtl/oled_cmd_table.sv
module oled_cmd_table
    import oled_pkg::*;
(
    input  job_e             job,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       height,
    input  logic [7:0]       contrast,
    output logic [7:0]       cmd_byte,
    output logic             last
);

    logic [7:0] mux_val;
    logic [7:0] pin_val;
    logic [7:0] dflt_contrast;

    always_comb begin
        mux_val       = (height == H_ROWS64) ? 8'h3F :
                        (height == H_ROWS48) ? 8'h2F : 8'h1F;
        pin_val       = (height == H_ROWS64 || height == H_ROWS48) ? 8'h12 : 8'h02;
        dflt_contrast = (height == H_ROWS64) ? 8'hCF : 8'h8F;
    end

    always_comb begin
        cmd_byte = 8'h00;
        last     = 1'b1;
        case (job)
            J_INIT: begin
                last = (int'(idx) == INIT_LEN - 1);
                case (int'(idx))
                    0:       cmd_byte = C_DISP_OFF;
                    1:       cmd_byte = 8'hD5;
                    2:       cmd_byte = 8'h80;
                    3:       cmd_byte = 8'hA8;
                    4:       cmd_byte = mux_val;
                    5:       cmd_byte = 8'hD3;
                    6:       cmd_byte = 8'h00;
                    7:       cmd_byte = 8'h40;
                    8:       cmd_byte = 8'h8D;
                    9:       cmd_byte = 8'h14;
                    10:      cmd_byte = 8'h20;
                    11:      cmd_byte = 8'h01;
                    12:      cmd_byte = 8'hA1;
                    13:      cmd_byte = 8'hC8;
                    14:      cmd_byte = 8'hDA;
                    15:      cmd_byte = pin_val;
                    16:      cmd_byte = 8'hD9;
                    17:      cmd_byte = 8'hF1;
                    18:      cmd_byte = 8'hDB;
                    19:      cmd_byte = 8'h40;
                    20:      cmd_byte = 8'hA4;
                    21:      cmd_byte = 8'hA6;
                    22:      cmd_byte = C_DISP_ON;
                    23:      cmd_byte = C_CONTRAST;
                    24:      cmd_byte = dflt_contrast;
                    default: cmd_byte = 8'h00;
                endcase
            end
            J_BLANK:    cmd_byte = C_DISP_OFF;
            J_UNBLANK:  cmd_byte = C_DISP_ON;
            J_CONTRAST: begin
                last     = (idx != '0);
                cmd_byte = (idx == '0) ? C_CONTRAST : contrast;
            end
            default: cmd_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/oled_spi_tx.sv
module oled_spi_tx #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       done,
    output logic       sck,
    output logic       mosi,
    output logic       cs_n
);

    localparam int DW = $clog2(CLK_DIV) + 1;

    typedef struct packed {
        logic          active;
        logic [7:0]    sh;
        logic [2:0]    bitn;
        logic [DW-1:0] cnt;
        logic          sck;
        logic          done;
    } tx_st_t;

    tx_st_t tx_d, tx_q;

    always_comb begin
        tx_d      = tx_q;
        tx_d.done = 1'b0;
        if (!tx_q.active) begin
            if (start) begin
                tx_d.active = 1'b1;
                tx_d.sh     = tx_byte;
                tx_d.bitn   = 3'd0;
                tx_d.cnt    = '0;
                tx_d.sck    = 1'b0;
            end
        end else if (tx_q.cnt == DW'(CLK_DIV - 1)) begin
            tx_d.cnt = '0;
            if (!tx_q.sck) begin
                tx_d.sck = 1'b1;
            end else begin
                tx_d.sck = 1'b0;
                if (tx_q.bitn == 3'd7) begin
                    tx_d.active = 1'b0;
                    tx_d.done   = 1'b1;
                end else begin
                    tx_d.bitn = tx_q.bitn + 3'd1;
                    tx_d.sh   = {tx_q.sh[6:0], 1'b0};
                end
            end
        end else begin
            tx_d.cnt = tx_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign done = tx_q.done;
    assign sck  = tx_q.sck;
    assign mosi = tx_q.sh[7];
    assign cs_n = !tx_q.active;

endmodule

// File: rtl/oled_init_seq.sv
module oled_init_seq
    import oled_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int RST_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] height_sel,
    input  logic       blank_req,
    input  logic       unblank_req,
    input  logic       contrast_req,
    input  logic [7:0] contrast_val,
    output logic       busy,
    output logic       panel_rst_n,
    output logic       spi_sck,
    output logic       spi_mosi,
    output logic       spi_cs_n,
    output logic       spi_dc
);

    localparam int RW = $clog2(RST_CYC) + 1;

    typedef struct packed {
        seq_state_e       state;
        job_e             job;
        logic [IDX_W-1:0] idx;
        logic [RW-1:0]    cnt;
        logic [7:0]       contrast;
    } seq_st_t;

    seq_st_t sq_d, sq_q;

    logic [7:0] cur_byte;
    logic       cur_last;
    logic       tx_done;
    logic       tx_start;

    oled_cmd_table u_table (
        .job      (sq_q.job),
        .idx      (sq_q.idx),
        .height   (height_sel),
        .contrast (sq_q.contrast),
        .cmd_byte (cur_byte),
        .last     (cur_last)
    );

    assign tx_start = (sq_q.state == S_SEND);

    oled_spi_tx #(.CLK_DIV(CLK_DIV)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tx_start),
        .tx_byte (cur_byte),
        .done    (tx_done),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n)
    );

    always_comb begin
        sq_d = sq_q;
        case (sq_q.state)
            S_RST_LO, S_RST_HI: begin
                if (sq_q.cnt == RW'(RST_CYC - 1)) begin
                    sq_d.cnt = '0;
                    if (sq_q.state == S_RST_LO) begin
                        sq_d.state = S_RST_HI;
                    end else begin
                        sq_d.state = S_SEND;
                        sq_d.job   = J_INIT;
                        sq_d.idx   = '0;
                    end
                end else begin
                    sq_d.cnt = sq_q.cnt + RW'(1);
                end
            end
            S_SEND: sq_d.state = S_WAIT;
            S_WAIT: begin
                if (tx_done) begin
                    if (cur_last) begin
                        sq_d.state = S_IDLE;
                    end else begin
                        sq_d.idx   = sq_q.idx + IDX_W'(1);
                        sq_d.state = S_SEND;
                    end
                end
            end
            S_IDLE: begin
                sq_d.idx = '0;
                if (blank_req) begin
                    sq_d.job   = J_BLANK;
                    sq_d.state = S_SEND;
                end else if (unblank_req) begin
                    sq_d.job   = J_UNBLANK;
                    sq_d.state = S_SEND;
                end else if (contrast_req) begin
                    sq_d.job      = J_CONTRAST;
                    sq_d.contrast = contrast_val;
                    sq_d.state    = S_SEND;
                end
            end
            default: sq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q.state    <= S_RST_LO;
            sq_q.job      <= J_INIT;
            sq_q.idx      <= '0;
            sq_q.cnt      <= '0;
            sq_q.contrast <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy        = (sq_q.state != S_IDLE);
    assign panel_rst_n = (sq_q.state != S_RST_LO);
    assign spi_dc      = !(sq_q.state == S_SEND || sq_q.state == S_WAIT);

endmodule

// File: rtl/oled_init_seq_chk.sv
module oled_init_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic panel_rst_n,
    input logic spi_sck,
    input logic spi_mosi,
    input logic spi_cs_n,
    input logic spi_dc
);

    p_dc_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !spi_dc)
        else $error("dc high inside a command frame");

    p_sck_framed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n)
        else $error("sck high outside a frame");

    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi))
        else $error("mosi moved while sck high");

    p_quiet_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n |-> (spi_cs_n && busy))
        else $error("traffic or idle while panel held in reset");

    p_reset_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        panel_rst_n |=> panel_rst_n)
        else $error("panel reset asserted again");

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n)
        else $error("frame active while not busy");

endmodule

bind oled_init_seq oled_init_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .panel_rst_n (panel_rst_n),
    .spi_sck     (spi_sck),
    .spi_mosi    (spi_mosi),
    .spi_cs_n    (spi_cs_n),
    .spi_dc      (spi_dc)
);

// File: tb/oled_init_seq_tb.sv
module oled_init_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int RCYC       = 4;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] height_sel = 2'd2;
    logic       blank_req = 1'b0;
    logic       unblank_req = 1'b0;
    logic       contrast_req = 1'b0;
    logic [7:0] contrast_val = 8'h00;
    logic       busy, panel_rst_n, spi_sck, spi_mosi, spi_cs_n, spi_dc;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [7:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    oled_init_seq #(.CLK_DIV(DIV), .RST_CYC(RCYC)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .height_sel   (height_sel),
        .blank_req    (blank_req),
        .unblank_req  (unblank_req),
        .contrast_req (contrast_req),
        .contrast_val (contrast_val),
        .busy         (busy),
        .panel_rst_n  (panel_rst_n),
        .spi_sck      (spi_sck),
        .spi_mosi     (spi_mosi),
        .spi_cs_n     (spi_cs_n),
        .spi_dc       (spi_dc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Monitor: rebuilds bytes from the link and pops the scoreboard.
    logic       prev_sck = 1'b0;
    logic       prev_cs  = 1'b1;
    int         nbits = 0;
    logic [7:0] shreg = 8'h00;
    int         ncyc = 0;
    int         last_rise = 0;

    always @(negedge clk) begin
        ncyc++;
        if (!rst_n) begin
            nbits    = 0;
            prev_sck = 1'b0;
            prev_cs  = 1'b1;
        end else begin
            if (spi_sck && !prev_sck) begin
                chk(!spi_cs_n && !spi_dc, "R2 frame/dc at sck rise", {spi_cs_n, spi_dc}, 0);
                if (nbits == 1) begin
                    chk(ncyc - last_rise == 2 * DIV, "R10 sck period", ncyc - last_rise, 2 * DIV);
                end
                last_rise = ncyc;
                shreg = {shreg[6:0], spi_mosi};
                nbits++;
                if (nbits == 8) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected byte", shreg, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(shreg == e, "R3/R4/R6/R7/R9 byte", shreg, e);
                    end
                end
            end
            if (spi_cs_n && !prev_cs) begin
                chk(nbits == 8, "R2 bits per frame", nbits, 8);
                nbits = 0;
            end
            prev_sck = spi_sck;
            prev_cs  = spi_cs_n;
        end
    end

    function automatic logic [7:0] exp_init(input int i, input logic [1:0] h);
        logic [7:0] m, p, c;
        m = (h == 2'd2) ? 8'h3F : (h == 2'd1) ? 8'h2F : 8'h1F;
        p = (h == 2'd2 || h == 2'd1) ? 8'h12 : 8'h02;
        c = (h == 2'd2) ? 8'hCF : 8'h8F;
        case (i)
            0: return 8'hAE;  1: return 8'hD5;  2: return 8'h80;  3: return 8'hA8;
            4: return m;      5: return 8'hD3;  6: return 8'h00;  7: return 8'h40;
            8: return 8'h8D;  9: return 8'h14;  10: return 8'h20; 11: return 8'h01;
            12: return 8'hA1; 13: return 8'hC8; 14: return 8'hDA; 15: return p;
            16: return 8'hD9; 17: return 8'hF1; 18: return 8'hDB; 19: return 8'h40;
            20: return 8'hA4; 21: return 8'hA6; 22: return 8'hAF; 23: return 8'h81;
            default: return c;
        endcase
    endfunction

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_init(input logic [1:0] h);
        int lo;
        int hi;
        @(negedge clk);
        rst_n = 1'b0;
        height_sel = h;
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R5 busy in reset", busy, 1);
        for (int i = 0; i < 25; i++) exp_q.push_back(exp_init(i, h));
        rst_n = 1'b1;
        lo = 0;
        while (!panel_rst_n) begin
            lo++;
            @(negedge clk);
        end
        chk(lo == RCYC, "R1 reset low length", lo, RCYC);
        hi = 0;
        while (spi_cs_n) begin
            hi++;
            @(negedge clk);
        end
        chk(hi >= RCYC, "R1 reset high before first frame", hi, RCYC);
        chk(busy == 1'b1, "R5 busy during power-up", busy, 1);
        wait_idle();
        chk(exp_q.size() == 0, "R3 R4 all power-up bytes seen", exp_q.size(), 0);
        chk(spi_cs_n == 1'b1, "R5 link quiet when idle", spi_cs_n, 1);
    endtask

    task automatic pulse(input logic b, input logic u, input logic c, input logic [7:0] v);
        blank_req    = b;
        unblank_req  = u;
        contrast_req = c;
        contrast_val = v;
        @(negedge clk);
        blank_req    = 1'b0;
        unblank_req  = 1'b0;
        contrast_req = 1'b0;
        contrast_val = 8'hEE;
    endtask

    initial begin
        do_init(2'd2);

        exp_q.push_back(8'h81); exp_q.push_back(8'h5A);
        pulse(1'b0, 1'b0, 1'b1, 8'h5A);
        wait_idle();
        chk(exp_q.size() == 0, "R7 contrast burst", exp_q.size(), 0);

        exp_q.push_back(8'hAE);
        pulse(1'b1, 1'b0, 1'b0, 8'h00);
        wait_idle();
        chk(exp_q.size() == 0, "R6 blank", exp_q.size(), 0);

        exp_q.push_back(8'hAF);
        pulse(1'b0, 1'b1, 1'b0, 8'h00);
        wait_idle();
        chk(exp_q.size() == 0, "R6 unblank", exp_q.size(), 0);

        exp_q.push_back(8'h81); exp_q.push_back(8'h33);
        pulse(1'b0, 1'b0, 1'b1, 8'h33);
        chk(busy == 1'b1, "R5 busy during burst", busy, 1);
        pulse(1'b1, 1'b1, 1'b1, 8'h77);
        repeat (5) @(negedge clk);
        pulse(1'b0, 1'b0, 1'b1, 8'h99);
        wait_idle();
        chk(exp_q.size() == 0, "R8 requests while busy ignored", exp_q.size(), 0);

        exp_q.push_back(8'hAE);
        pulse(1'b1, 1'b1, 1'b1, 8'h44);
        wait_idle();
        chk(exp_q.size() == 0, "R9 blank wins", exp_q.size(), 0);

        exp_q.push_back(8'hAF);
        pulse(1'b0, 1'b1, 1'b1, 8'h44);
        wait_idle();
        chk(exp_q.size() == 0, "R9 unblank beats contrast", exp_q.size(), 0);

        do_init(2'd1);
        do_init(2'd0);
        do_init(2'd3);

        exp_q.push_back(8'h81); exp_q.push_back(8'hFF);
        pulse(1'b0, 1'b0, 1'b1, 8'hFF);
        wait_idle();
        chk(exp_q.size() == 0, "R7 contrast max value", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule